// File: doc/BRIEF.md
# Privilege-Filtered Sampling Event Counter

This block counts micro-architectural events for performance sampling. Each cycle it receives a vector of up to sixteen event indications belonging to one event class, along with the current privilege level and a micro-op tag. A 64-bit control register decides what qualifies. It selects the class to match and a mask of the events within that class, it enables counting in user mode (levels 1 to 3) and in kernel mode (level 0) separately, and it can optionally require a tag match. The number of qualifying events in a cycle is added to a 40-bit counter.

Software presets the counter to a modulus value, so that a chosen number of events carries it past its top bit. The carry sets a sticky interrupt request, and the counter wraps to zero and goes on counting. A simple register port writes and reads the control register, the counter and a status word. The status word holds the interrupt flag, which software clears by writing a one to it.

Top module: `pmc_sampler`

## Requirements
- R1: After reset the control register, the counter and the interrupt request are all zero.
- R2: Control bit 2 enables counting while cur_priv is 1, 2 or 3.
- R3: Control bit 3 enables counting while cur_priv is 0; with bits 2 and 3 both clear nothing is counted.
- R4: When control bit 4 is set, a cycle's events count only if uop_tag equals control bits 8:5.
- R5: A cycle's events count only if ev_class equals control bits 30:25.
- R6: A qualifying cycle adds the number of set bits of ev_hits AND control bits 24:9 to the counter, and the sum is readable at address 1 after the next rising edge.
- R7: Control bits 1:0 and 63:31 ignore writes and read as zero at address 0.
- R8: A write to address 1 loads the counter with wdata[39:0], and it takes priority over any increment in the same cycle.
- R9: A carry out of counter bit 39 leaves the counter at the sum modulo 2^40 and sets pmi_req on the same edge.
- R10: pmi_req stays set until a write to address 2 with wdata bit 0 set; writing 0 does not clear it, and an overflow in the clearing cycle keeps it set.
- R11: A write to address 0 governs only events presented from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 control, 1 counter, 2 status |
| reg_wdata | input | 64 | Write data |
| reg_rd_addr | input | 2 | Read address, same map |
| reg_rdata | output | 64 | Read data (combinational from registers) |
| ev_hits | input | 16 | Event indications this cycle |
| ev_class | input | 6 | Class identifier of ev_hits |
| cur_priv | input | 2 | Current privilege level |
| uop_tag | input | 4 | Tag carried by the events |
| pmi_req | output | 1 | Sticky overflow interrupt request |

## Verification
If the qualification logic picked the wrong class, privilege level or tag, the counter read at address 1 would be wrong one edge after the offending event cycle. Because the value accumulates, the error stays visible on every later read until software reloads the counter. A wrong carry or wrap shows on pmi_req and the counter at the edge where the sum crosses 2^40. A lost or stuck sticky flag shows on pmi_req within a cycle of the clearing write.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int EVT_W = 16;
    localparam int CLS_W = 6;
    localparam int TAG_W = 4;
    localparam int INC_W = $clog2(EVT_W + 1);
    localparam int REG_W = 64;

    // Control layout; the field positions are what software programs.
    typedef struct packed {
        logic [32:0]      rsv_hi;    // 63:31
        logic [CLS_W-1:0] cls_sel;   // 30:25
        logic [EVT_W-1:0] evt_mask;  // 24:9
        logic [TAG_W-1:0] tag_val;   // 8:5
        logic             tag_en;    // 4
        logic             kern_en;   // 3
        logic             user_en;   // 2
        logic [1:0]       rsv_lo;    // 1:0
    } ctl_t;

    typedef enum logic [1:0] {
        ADDR_CTL  = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_STAT = 2'd2
    } reg_addr_e;

    function automatic ctl_t ctl_sanitize(input logic [REG_W-1:0] raw);
        ctl_t c;
        c        = ctl_t'(raw);
        c.rsv_hi = '0;
        c.rsv_lo = '0;
        return c;
    endfunction

endpackage

// File: rtl/pmc_event_qual.sv
module pmc_event_qual
    import pmc_pkg::*;
(
    input  ctl_t             ctl,
    input  logic [EVT_W-1:0] hits,
    input  logic [CLS_W-1:0] cls,
    input  logic [1:0]       priv,
    input  logic [TAG_W-1:0] tag,
    output logic [INC_W-1:0] inc
);

    logic [EVT_W-1:0] masked;
    logic             priv_ok;
    logic             cls_ok;
    logic             tag_ok;
    logic [INC_W-1:0] pop;

    assign masked  = hits & ctl.evt_mask;
    assign priv_ok = (priv == 2'd0) ? ctl.kern_en : ctl.user_en;
    assign cls_ok  = (cls == ctl.cls_sel);
    assign tag_ok  = !ctl.tag_en || (tag == ctl.tag_val);

    always_comb begin
        pop = '0;
        for (int i = 0; i < EVT_W; i++) begin
            pop = pop + INC_W'(masked[i]);
        end
    end

    assign inc = (priv_ok && cls_ok && tag_ok) ? pop : '0;

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int CNT_W = 40,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum      = {1'b0, st_q.cnt} + (CNT_W+1)'(inc);
        st_d     = st_q;
        wrap     = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else begin
            st_d.cnt = sum[CNT_W-1:0];
            wrap     = sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_stat,
    input  logic [REG_W-1:0] wdata,
    input  logic             wrap,
    output ctl_t             ctl,
    output logic             irq
);

    typedef struct packed {
        ctl_t ctl;
        logic irq;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_ctl) begin
            rg_d.ctl = ctl_sanitize(wdata);
        end
        // Overflow outranks a clear issued in the same cycle.
        if (wrap) begin
            rg_d.irq = 1'b1;
        end else if (wr_stat && wdata[0]) begin
            rg_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign ctl = rg_q.ctl;
    assign irq = rg_q.irq;

endmodule

// File: rtl/pmc_sampler.sv
module pmc_sampler
    import pmc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    input  logic [1:0]       reg_rd_addr,
    output logic [63:0]      reg_rdata,
    input  logic [15:0]      ev_hits,
    input  logic [5:0]       ev_class,
    input  logic [1:0]       cur_priv,
    input  logic [3:0]       uop_tag,
    output logic             pmi_req
);

    ctl_t             ctl_w;
    logic [CNT_W-1:0] cnt_w;
    logic [INC_W-1:0] inc_w;
    logic             wrap_w;
    logic             wr_ctl, wr_cnt, wr_stat;

    assign wr_ctl  = reg_wr_en && (reg_addr == ADDR_CTL);
    assign wr_cnt  = reg_wr_en && (reg_addr == ADDR_CNT);
    assign wr_stat = reg_wr_en && (reg_addr == ADDR_STAT);

    pmc_event_qual u_qual (
        .ctl  (ctl_w),
        .hits (ev_hits),
        .cls  (ev_class),
        .priv (cur_priv),
        .tag  (uop_tag),
        .inc  (inc_w)
    );

    pmc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .inc      (inc_w),
        .cnt      (cnt_w),
        .wrap     (wrap_w)
    );

    pmc_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl),
        .wr_stat (wr_stat),
        .wdata   (reg_wdata),
        .wrap    (wrap_w),
        .ctl     (ctl_w),
        .irq     (pmi_req)
    );

    always_comb begin
        unique case (reg_rd_addr)
            ADDR_CTL:  reg_rdata = ctl_w;
            ADDR_CNT:  reg_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_w};
            ADDR_STAT: reg_rdata = {{(REG_W-1){1'b0}}, pmi_req};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmc_sampler_chk.sv
module pmc_sampler_chk
    import pmc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [63:0]      wr_data,
    input logic [5:0]       ev_class,
    input logic [CNT_W-1:0] cnt,
    input ctl_t             ctl,
    input logic             irq
);

    logic cnt_wr, clr_wr;
    assign cnt_wr = wr_en && (wr_addr == 2'd1);
    assign clr_wr = wr_en && (wr_addr == 2'd2) && wr_data[0];

    // R6: one cycle never advances the counter by more than EVT_W
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_wr) |-> ((cnt - $past(cnt)) <= CNT_W'(EVT_W)));

    // R9: counter moving backwards without a load means a wrap, so irq is set
    a_r9_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && (cnt < $past(cnt))) |-> irq);

    // R10: once set, irq holds unless cleared
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(clr_wr)) |-> irq);

    // R3: both privilege enables clear leaves the counter still
    a_r3_no_priv_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && !$past(ctl.user_en) && !$past(ctl.kern_en)) |-> $stable(cnt));

    // R5: class mismatch leaves the counter still
    a_r5_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && ($past(ev_class) != $past(ctl.cls_sel))) |-> $stable(cnt));

    // R7: reserved fields stay zero
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rsv_hi == '0) && (ctl.rsv_lo == '0));

endmodule

bind pmc_sampler pmc_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .ev_class (ev_class),
    .cnt      (cnt_w),
    .ctl      (ctl_w),
    .irq      (pmi_req)
);

// File: tb/pmc_sampler_tb.sv
module pmc_sampler_tb;

    localparam int  CNT_W = 40;
    localparam logic [63:0] KEEP = 64'h0000_0000_7FFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [1:0]  reg_rd_addr = 2'd0;
    logic [63:0] reg_rdata;
    logic [15:0] ev_hits = '0;
    logic [5:0]  ev_class = '0;
    logic [1:0]  cur_priv = '0;
    logic [3:0]  uop_tag = '0;
    logic        pmi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0]      m_ctl;
    logic [CNT_W-1:0] m_cnt;
    logic             m_irq;

    always #10 clk = ~clk;

    pmc_sampler #(.CNT_W(CNT_W)) u_dut (.*);

    function automatic logic [63:0] mk_ctl(input bit usr, input bit krn, input bit ten,
                                           input logic [3:0] tv, input logic [15:0] msk,
                                           input logic [5:0] cs);
        return {33'b0, cs, msk, tv, ten, krn, usr, 2'b00};
    endfunction

    function automatic int qual(input logic [63:0] c, input logic [15:0] h,
                                input logic [5:0] cs, input logic [1:0] p, input logic [3:0] t);
        int n = 0;
        bit ok;
        logic [15:0] m;
        ok = (p == 2'd0) ? c[3] : c[2];
        if (cs != c[30:25]) ok = 0;
        if (c[4] && (t != c[8:5])) ok = 0;
        m = h & c[24:9];
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return ok ? n : 0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input bit we, input logic [1:0] wa, input logic [63:0] wd,
                        input logic [15:0] h, input logic [5:0] cs,
                        input logic [1:0] p, input logic [3:0] t);
        logic [CNT_W:0] sum;
        bit ov;
        reg_wr_en = we; reg_addr = wa; reg_wdata = wd;
        ev_hits = h; ev_class = cs; cur_priv = p; uop_tag = t;
        ov = 0;
        sum = {1'b0, m_cnt} + (CNT_W+1)'(qual(m_ctl, h, cs, p, t));
        if (we && wa == 2'd1) m_cnt = wd[CNT_W-1:0];
        else begin m_cnt = sum[CNT_W-1:0]; ov = sum[CNT_W]; end
        if (ov) m_irq = 1'b1;
        else if (we && wa == 2'd2 && wd[0]) m_irq = 1'b0;
        if (we && wa == 2'd0) m_ctl = wd & KEEP;
        @(posedge clk);
        #2;
        reg_wr_en = 1'b0; ev_hits = '0;
    endtask

    task automatic check_all(input string req);
        reg_rd_addr = 2'd0; #1 check({req, " ctl"}, reg_rdata, m_ctl);
        reg_rd_addr = 2'd1; #1 check({req, " cnt"}, reg_rdata, {24'b0, m_cnt});
        reg_rd_addr = 2'd2; #1 check({req, " stat"}, reg_rdata, {63'b0, m_irq});
        check({req, " pmi_req"}, {63'b0, pmi_req}, {63'b0, m_irq});
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        tick(1'b1, a, d, 16'h0, 6'h3F, 2'd0, 4'h0);
    endtask

    initial begin
        m_ctl = '0; m_cnt = '0; m_irq = 1'b0;
        void'($urandom(32'd20240611));
        #35 rst_n = 1'b1;
        @(posedge clk); #2;
        check_all("R1 reset");

        // R2: user enable only
        wr(2'd0, mk_ctl(1, 0, 0, 0, 16'hFFFF, 6'd5));
        tick(0, 0, 0, 16'h00F3, 6'd5, 2'd0, 0); check_all("R3 kernel level blocked by user-only");
        tick(0, 0, 0, 16'h00F3, 6'd5, 2'd2, 0); check_all("R2 user level counts");
        tick(0, 0, 0, 16'hFFFF, 6'd5, 2'd3, 0); check_all("R6 full vector popcount");
        // R3: kernel only
        wr(2'd0, mk_ctl(0, 1, 0, 0, 16'h0F0F, 6'd5));
        tick(0, 0, 0, 16'hFFFF, 6'd5, 2'd1, 0); check_all("R3 user level blocked by kernel-only");
        tick(0, 0, 0, 16'hFFFF, 6'd5, 2'd0, 0); check_all("R6 masked count at kernel");
        // R3: neither
        wr(2'd0, mk_ctl(0, 0, 0, 0, 16'hFFFF, 6'd5));
        tick(0, 0, 0, 16'hFFFF, 6'd5, 2'd0, 0);
        tick(0, 0, 0, 16'hFFFF, 6'd5, 2'd2, 0); check_all("R3 no enables nothing counts");
        // R7
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF); check_all("R7 reserved bits read zero");
        // R4
        wr(2'd0, mk_ctl(1, 1, 1, 4'hA, 16'hFFFF, 6'd9));
        tick(0, 0, 0, 16'h0007, 6'd9, 2'd1, 4'h3); check_all("R4 tag mismatch blocked");
        tick(0, 0, 0, 16'h0007, 6'd9, 2'd1, 4'hA); check_all("R4 tag match counts");
        // R5
        tick(0, 0, 0, 16'h0007, 6'd8, 2'd1, 4'hA); check_all("R5 class mismatch blocked");
        // R8: load beats increment
        tick(1, 2'd1, 64'hFFFF_FF12_3456_789A, 16'hFFFF, 6'd9, 2'd0, 4'hA);
        check_all("R8 load wins over increment");
        // R9: wrap with multi-event increment
        wr(2'd1, 64'h00FF_FFFF_FFFD);
        tick(0, 0, 0, 16'h001F, 6'd9, 2'd0, 4'hA); check_all("R9 wrap sets irq");
        tick(0, 0, 0, 16'h0000, 6'd9, 2'd0, 4'hA); check_all("R10 irq sticky");
        wr(2'd2, 64'h2); check_all("R10 write of zero bit keeps irq");
        wr(2'd2, 64'h1); check_all("R10 clear");
        // R10: overflow in clearing cycle keeps irq
        wr(2'd1, 64'h00FF_FFFF_FFFF);
        tick(1, 2'd2, 64'h1, 16'h0001, 6'd9, 2'd0, 4'hA); check_all("R10 set beats clear");
        wr(2'd2, 64'h1);
        // R11: ctl write uses old ctl this cycle
        tick(1, 2'd0, mk_ctl(1, 1, 0, 0, 16'hFFFF, 6'd2), 16'h0003, 6'd2, 2'd0, 4'h0);
        check_all("R11 old ctl governs write cycle");
        tick(0, 0, 0, 16'h0003, 6'd2, 2'd0, 4'h0); check_all("R11 new ctl next cycle");

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            logic [63:0] d;
            r = $urandom;
            if (r[3:0] == 4'd0) begin
                d = {$urandom, $urandom};
                d[30:25] = {4'b0, r[9:8]};
                tick(1, 2'd0, d, 16'(($urandom)), {4'b0, r[11:10]}, r[13:12], r[17:14]);
            end else if (r[3:0] == 4'd1) begin
                d = {24'b0, 16'hFFFF, 8'hFF, 16'(($urandom))};
                if (r[4]) d = {$urandom, $urandom};
                tick(1, 2'd1, d, 16'(($urandom)), {4'b0, r[11:10]}, r[13:12], r[17:14]);
            end else if (r[3:0] == 4'd2) begin
                tick(1, 2'd2, {63'b0, r[5]}, 16'(($urandom)), {4'b0, r[11:10]}, r[13:12], r[17:14]);
            end else begin
                tick(0, 0, 0, 16'(($urandom)), {4'b0, r[11:10]}, r[13:12], r[17:14]);
            end
            check_all("R6 R9 random compare");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule